// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block collects thirteen level-sensitive board interrupt lines and presents the most urgent enabled one to a processor as a 4-bit interrupt level. Each line is captured into a 16-bit monitor register. A 16-bit mask register, written by software, enables lines individually. Every source has a fixed urgency level and its own bit position, and the two are unrelated. The lowest-numbered level among the pending sources wins. That level is inverted (XOR 15) before it leaves the block, so an output of zero means no request.

A 64-byte register window sits on a simple synchronous bus. It holds the mask, a read-only version word, a general output port and a power-off control. Writing the power-off control with bit 0 set raises a one-cycle shutdown pulse.

Top module: `irl_encoder`

## Requirements
- R1: After reset, `irl_out` is 0, `shutdown` is 0, and the mask register and the output port both read 0.
- R2: The monitor follows the levels of `src_in`. Source index i maps to a fixed mask bit: 0→9, 1→8, 2→14, 3→13, 4→12, 5→11, 6→10, 7→6, 8→5, 9→4, 10→7, 11→0, 12→15. A source is pending only when its line is high and its own mask bit is set. Mask bits 1, 2 and 3 belong to no source and enable nothing.
- R3: Each source index has a fixed level: 0→1, 1→2, 2→9, 3→10, 4→3, 5→0, 6→4, 7→5, 8→6, 9→7, 10→8, 11→11, 12→12. Among the pending sources, the one with the numerically lowest level wins.
- R4: `irl_out` equals the winning level XOR 15. With nothing pending, `irl_out` is 0.
- R5: `irl_out` is registered. A change on `src_in` shows on `irl_out` after the second rising edge. A mask write shows on `irl_out` one rising edge after the edge that stores it.
- R6: The mask register at byte offset 0x00 is 16 bits wide and reads back the value last written.
- R7: Offset 0x32 reads the `VERSION` parameter. Writes to 0x32 have no effect.
- R8: The output port at offset 0x36 reads back the value last written and drives `port_out` from the edge after the write.
- R9: A write to offset 0x30 with `wdata[0]`=1 makes `shutdown` high for exactly the one cycle after the write edge. A write there with `wdata[0]`=0 gives no pulse. A read of 0x30 returns 0.
- R10: A read of an unmapped offset returns 0. Writes to unmapped offsets change neither the mask nor the output port. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 13 | Interrupt source lines, high means asserted |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset within the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irl_out | output | 4 | Inverted winning level, 0 when idle |
| shutdown | output | 1 | One-cycle power-off pulse |
| port_out | output | 16 | Output port register contents |

## Verification
The assertions take `src_in` to be synchronous to `clk`. They also take each bus write to be a single-cycle strobe with stable address and data, because the one-cycle pulse property and the port-capture property only make sense under that rule. The bench changes every input just after a falling edge. It raises `wr_en` for exactly one cycle per access and reads back over `rd_en` only between edges. The mask and source patterns are chosen so that the lowest pending level lands in turn on different sources, including ones whose mask bit is far from their level.

// File: rtl/irl_encoder.sv
module irl_encoder #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 16,
  parameter logic [15:0] VERSION = 16'h0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       src_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        irl_out,
  output logic              shutdown,
  output logic [DATA_W-1:0] port_out
);
  localparam int unsigned NSRC = 13;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(6'h32);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(6'h36);

  localparam logic [3:0] LVL [NSRC] = '{4'd1, 4'd2, 4'd9, 4'd10, 4'd3, 4'd0, 4'd4,
                                        4'd5, 4'd6, 4'd7, 4'd8, 4'd11, 4'd12};
  localparam int unsigned POS [NSRC] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};

  logic [15:0] mon_q, mask_q, mon_d, pend;
  logic [3:0]  best;

  always_comb begin
    mon_d = '0;
    for (int i = 0; i < NSRC; i++)
      mon_d[POS[i]] = src_in[i];
  end

  assign pend = mon_q & mask_q;

  always_comb begin
    best = 4'hF;
    for (int i = 0; i < NSRC; i++)
      if (pend[POS[i]] && LVL[i] < best) best = LVL[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q    <= '0;
      mask_q   <= '0;
      port_out <= '0;
      irl_out  <= '0;
      shutdown <= 1'b0;
    end else begin
      mon_q    <= mon_d;
      irl_out  <= best ^ 4'hF;
      shutdown <= wr_en && addr == A_PWR && wdata[0];
      if (wr_en && addr == A_MASK) mask_q   <= wdata[15:0];
      if (wr_en && addr == A_PORT) port_out <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        A_MASK:  rdata = DATA_W'(mask_q);
        A_VER:   rdata = DATA_W'(VERSION);
        A_PORT:  rdata = port_out;
        default: rdata = '0;
      endcase
  end
endmodule

module irl_encoder_chk #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 16,
  parameter logic [15:0] VERSION = 16'h0101
) (
  input logic              clk,
  input logic              rst_n,
  input logic [12:0]       src_in,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [3:0]        irl_out,
  input logic              shutdown,
  input logic [DATA_W-1:0] port_out
);
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !shutdown); // R9
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(wr_en && addr == ADDR_W'(6'h30) && wdata[0])); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in == '0 && $past(src_in == '0)) |=> irl_out == 4'd0); // R4
  AST_PORT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(6'h36)) |=> port_out == $past(wdata)); // R8
  AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(6'h32)) |-> rdata == DATA_W'(VERSION)); // R7
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0); // R10
endmodule

bind irl_encoder irl_encoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irl_out(irl_out),
  .shutdown(shutdown), .port_out(port_out)
);

// File: tb/tb_irl_encoder.sv
module tb_irl_encoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VER = 16'h0101;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [12:0] src_in = '0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, port_out;
  logic [3:0]  irl_out;
  logic        shutdown;
  int total = 0, bad = 0;
  logic finished = 0;

  irl_encoder #(.VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irl_out(irl_out),
    .shutdown(shutdown), .port_out(port_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {src_in, mask, expected irl_out}
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {13'h1FFF, 16'hFFFF, 4'd15},
    {13'h1FFF, 16'hF7FF, 4'd14},
    {13'h0800, 16'hFFFF, 4'd4},
    {13'h1000, 16'h8000, 4'd3},
    {13'h1800, 16'h0001, 4'd4},
    {13'h000C, 16'hFFFF, 4'd6},
    {13'h0480, 16'hFFFF, 4'd10},
    {13'h1FFF, 16'h0000, 4'd0},
    {13'h0300, 16'h0010, 4'd8},
    {13'h0050, 16'hFFFF, 4'd12},
    {13'h0000, 16'hFFFF, 4'd0},
    {13'h0002, 16'h0100, 4'd13},
    {13'h1FFF, 16'h000E, 4'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 d = rdata;
    rd_en = 0; addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    check("R1 irl", 16'(irl_out), 16'd0);
    check("R1 shutdown", 16'(shutdown), 16'd0);
    rst_n = 1;
    bus_read(6'h00, r); check("R1 mask", r, 16'h0000);
    bus_read(6'h36, r); check("R1 port", r, 16'h0000);
    check("R1 port_out", port_out, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      bus_write(6'h00, VEC[v][19:4]);
      src_in = VEC[v][32:20];
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R2 R3 R4 vector", 16'(irl_out), 16'(VEC[v][3:0]));
    end

    // R5 source latency
    bus_write(6'h00, 16'hFFFF);
    src_in = '0;
    repeat (3) @(negedge clk);
    src_in = 13'h0800;
    @(negedge clk); check("R5 src one edge", 16'(irl_out), 16'd0);
    @(negedge clk); check("R5 src two edges", 16'(irl_out), 16'd4);
    // R5 mask latency
    bus_write(6'h00, 16'h0000);
    src_in = 13'h1FFF;
    repeat (2) @(negedge clk);
    check("R5 masked idle", 16'(irl_out), 16'd0);
    wr_en = 1; addr = 6'h00; wdata = 16'hFFFF;
    @(negedge clk); wr_en = 0; wdata = '0;
    check("R5 mask one edge", 16'(irl_out), 16'd0);
    @(negedge clk); check("R5 mask two edges", 16'(irl_out), 16'd15);

    // R6 mask readback
    bus_write(6'h00, 16'hA5C3);
    bus_read(6'h00, r); check("R6 mask rb", r, 16'hA5C3);

    // R7 version
    bus_read(6'h32, r); check("R7 version", r, VER);
    bus_write(6'h32, 16'h1234);
    bus_read(6'h32, r); check("R7 version after write", r, VER);

    // R8 output port
    bus_write(6'h36, 16'h5A0F);
    check("R8 port_out", port_out, 16'h5A0F);
    bus_read(6'h36, r); check("R8 port rb", r, 16'h5A0F);

    // R10 unmapped
    bus_write(6'h04, 16'hFFFF);
    bus_write(6'h3E, 16'h0000);
    bus_read(6'h00, r); check("R10 mask kept", r, 16'hA5C3);
    bus_read(6'h36, r); check("R10 port kept", r, 16'h5A0F);
    bus_read(6'h02, r); check("R10 unmapped read", r, 16'h0000);
    check("R10 rdata idle", rdata, 16'h0000);

    // R9 power-off
    @(negedge clk);
    wr_en = 1; addr = 6'h30; wdata = 16'h0001;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
    check("R9 pulse high", 16'(shutdown), 16'd1);
    @(negedge clk); check("R9 pulse low", 16'(shutdown), 16'd0);
    @(negedge clk);
    wr_en = 1; addr = 6'h30; wdata = 16'hFFFE;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
    check("R9 bit0 clear no pulse", 16'(shutdown), 16'd0);
    bus_read(6'h30, r); check("R9 read zero", r, 16'h0000);

    // R1 reset again
    rst_n = 0;
    @(negedge clk);
    check("R1 irl after reset", 16'(irl_out), 16'd0);
    check("R1 port_out after reset", port_out, 16'h0000);
    rst_n = 1;
    bus_read(6'h00, r); check("R1 mask after reset", r, 16'h0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule